// File: doc/BRIEF.md
# Coalesced Request Inflight Table

This block keeps track of coalesced memory requests that are still waiting for a response. When a coalesced request goes out, the issuing logic writes one row into the table. The row lists, for each lane, a fixed number of original per-lane requests that were merged into the coalesced one. Each recorded request keeps its own original source ID and its word offset inside the coalesced access. The table hands back the coalesced source ID under which the row was stored. Row index and coalesced source ID are the same number, so the storage is plain indexed registers and needs no associative match.

When the response comes back, the response side raises a ready input and supplies the response's source ID on a key input. The table answers in the same cycle with a valid flag and the stored row. On the clock edge where the result is taken, the row is freed. Fresh IDs are handed out by a rotating counter that skips rows still in use. Two requests in flight therefore never share an ID. An enqueue and a lookup that land in the same cycle both take effect.

Top module: `ict_table`

## Requirements
- R1: After reset no row is in use: `full_o` is 0, `enq_ready_o` is 1, `enq_id_o` is 0, and a lookup of any key returns `lk_valid_o` = 0.
- R2: New IDs come from a counter. After each accepted enqueue the counter becomes the granted ID plus one, wrapping modulo 2^ID_W. The next grant is searched from that counter value, so with all rows free the grants after reset are 0, 1, 2 and so on.
- R3: An accepted enqueue (`enq_valid_i` and `enq_ready_o` both 1) stores `enq_row_i` in the row numbered `enq_id_o`. A later hitting lookup of that key returns exactly that value. Within a row, the slot for lane l and slot s has index l*SLOTS+s and occupies bits [idx*SW +: SW], where SW = 1+LSRC_W+OFF_W. Inside a slot, bit SW-1 flags a used slot, the next LSRC_W bits hold the original source ID, and the low OFF_W bits hold the word offset.
- R4: A lookup whose key names a row that is not in use returns `lk_valid_o` = 0 and changes no row.
- R5: A hitting lookup frees its row on that clock edge. A lookup of the same key in the next cycle misses.
- R6: `lk_valid_o` is 0 in every cycle in which `lk_ready_i` is 0.
- R7: The granted `enq_id_o` never names a row in use. It is the first free row found when searching upward from the counter, with wrap-around.
- R8: `full_o` is 1 exactly when every row is in use. While it is 1, `enq_ready_o` is 0 and `enq_valid_i` changes no row.
- R9: An accepted enqueue and a hitting lookup in the same cycle both take effect: the new row is stored and the looked-up row is freed.
- R10: When the table is full and a lookup frees a row, `full_o` drops in the next cycle and `enq_id_o` names the freed row if it is the only free row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enq_valid_i | input | 1 | Request to store a new row |
| enq_ready_o | output | 1 | A free row exists; the enqueue is accepted |
| enq_row_i | input | LANES*SLOTS*(1+LSRC_W+OFF_W) | Row contents to store |
| enq_id_o | output | ID_W | Coalesced source ID granted to the enqueue |
| full_o | output | 1 | Every row is in use |
| lk_ready_i | input | 1 | Lookup request; consumes the result when it hits |
| lk_key_i | input | ID_W | Source ID to look up |
| lk_valid_o | output | 1 | The keyed row is in use |
| lk_row_o | output | LANES*SLOTS*(1+LSRC_W+OFF_W) | Contents of the keyed row |

## Verification
Enqueue and lookup are the two functions that can fall in the same cycle. The bench provokes this on purpose twice. First, it looks up an occupied row while enqueuing into another row. Second, while the table is full, it looks up a row and also raises an enqueue, which must be refused in that cycle and granted the freed row in the next. A mixed phase then drives both ports with independent pseudo-random choices. A scoreboard model of row occupancy, contents and the ID counter predicts every grant and every lookup result, and later lookups show that neither operation in a shared cycle was lost.

// File: rtl/ict_pkg.sv
package ict_pkg;
  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_SLOTS  = 2;
  localparam int unsigned DEF_ID_W   = 3;
  localparam int unsigned DEF_LSRC_W = 4;
  localparam int unsigned DEF_OFF_W  = 2;

  function automatic int unsigned slot_bits(int unsigned lsrc_w, int unsigned off_w);
    return 1 + lsrc_w + off_w;
  endfunction
endpackage

// File: rtl/ict_alloc.sv
module ict_alloc #(
  parameter int unsigned ID_W = 3
) (
  input  logic [2**ID_W-1:0] busy_i,
  input  logic [ID_W-1:0]    base_i,
  output logic               found_o,
  output logic [ID_W-1:0]    idx_o
);
  localparam int unsigned ROWS = 2**ID_W;

  // rotating priority: lowest distance from base wins
  always_comb begin
    logic [ID_W-1:0] cand;
    cand    = base_i;
    found_o = 1'b0;
    idx_o   = base_i;
    for (int k = ROWS - 1; k >= 0; k--) begin
      cand = base_i + ID_W'(k);
      if (!busy_i[cand]) begin
        found_o = 1'b1;
        idx_o   = cand;
      end
    end
  end
endmodule

// File: rtl/ict_store.sv
module ict_store #(
  parameter int unsigned ID_W  = 3,
  parameter int unsigned ROW_W = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ID_W-1:0]   set_idx_i,
  input  logic [ROW_W-1:0]  set_data_i,
  input  logic              clr_i,
  input  logic [ID_W-1:0]   clr_idx_i,
  input  logic [ID_W-1:0]   rd_idx_i,
  output logic [2**ID_W-1:0] busy_o,
  output logic [ROW_W-1:0]  rd_data_o
);
  localparam int unsigned ROWS = 2**ID_W;

  logic [ROWS-1:0]  busy_q;
  logic [ROW_W-1:0] data_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  busy_q[r] <= 1'b0;
      else if (set_i && set_idx_i == ID_W'(r))      busy_q[r] <= 1'b1;
      else if (clr_i && clr_idx_i == ID_W'(r))      busy_q[r] <= 1'b0;
    end

    always_ff @(posedge clk_i) begin
      if (set_i && set_idx_i == ID_W'(r)) data_q[r] <= set_data_i;
    end
  end

  assign busy_o    = busy_q;
  assign rd_data_o = data_q[rd_idx_i];

  // allocation and release never target the same row
  p_no_set_clr_clash_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i && set_idx_i == clr_idx_i));
endmodule

// File: rtl/ict_table.sv
module ict_table
  import ict_pkg::*;
#(
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned ID_W   = DEF_ID_W,
  parameter int unsigned LSRC_W = DEF_LSRC_W,
  parameter int unsigned OFF_W  = DEF_OFF_W
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         enq_valid_i,
  output logic                                         enq_ready_o,
  input  logic [LANES*SLOTS*(1+LSRC_W+OFF_W)-1:0]      enq_row_i,
  output logic [ID_W-1:0]                              enq_id_o,
  output logic                                         full_o,
  input  logic                                         lk_ready_i,
  input  logic [ID_W-1:0]                              lk_key_i,
  output logic                                         lk_valid_o,
  output logic [LANES*SLOTS*(1+LSRC_W+OFF_W)-1:0]      lk_row_o
);
  localparam int unsigned SW    = slot_bits(LSRC_W, OFF_W);
  localparam int unsigned ROW_W = LANES * SLOTS * SW;
  localparam int unsigned ROWS  = 2**ID_W;

  logic [ROWS-1:0] busy;
  logic [ID_W-1:0] ptr_q;
  logic            found;
  logic [ID_W-1:0] free_idx;
  logic            enq_fire;

  ict_alloc #(.ID_W(ID_W)) alloc_i (
    .busy_i  (busy),
    .base_i  (ptr_q),
    .found_o (found),
    .idx_o   (free_idx)
  );

  assign enq_ready_o = found;
  assign full_o      = ~found;
  assign enq_id_o    = free_idx;
  assign enq_fire    = enq_valid_i & found;
  assign lk_valid_o  = lk_ready_i & busy[lk_key_i];

  ict_store #(.ID_W(ID_W), .ROW_W(ROW_W)) store_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (enq_fire),
    .set_idx_i  (free_idx),
    .set_data_i (enq_row_i),
    .clr_i      (lk_valid_o),
    .clr_idx_i  (lk_key_i),
    .rd_idx_i   (lk_key_i),
    .busy_o     (busy),
    .rd_data_o  (lk_row_o)
  );

  // ID counter: next search starts just past the last grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (enq_fire) ptr_q <= free_idx + ID_W'(1);
  end

  p_ptr_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_fire |=> ptr_q == $past(enq_id_o) + ID_W'(1));
  p_row_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_fire |=> busy[$past(enq_id_o)]);
  p_miss_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_ready_i && !lk_valid_o && !enq_fire) |=> $stable(busy));
  p_hit_frees_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_o |=> !busy[$past(lk_key_i)]);
  p_grant_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enq_ready_o |-> !busy[enq_id_o]);
  p_full_all_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (&busy));
  p_full_frozen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !lk_valid_o) |=> $stable(busy));
endmodule

// File: tb/ict_table_tb_top.sv
module ict_table_tb_top;
  localparam int unsigned LANES = 4, SLOTS = 2, ID_W = 3, LSRC_W = 4, OFF_W = 2;
  localparam int unsigned ROW_W = LANES * SLOTS * (1 + LSRC_W + OFF_W);
  localparam int unsigned ROWS  = 2**ID_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enq_valid_i = 1'b0;
  logic             enq_ready_o;
  logic [ROW_W-1:0] enq_row_i = '0;
  logic [ID_W-1:0]  enq_id_o;
  logic             full_o;
  logic             lk_ready_i = 1'b0;
  logic [ID_W-1:0]  lk_key_i = '0;
  logic             lk_valid_o;
  logic [ROW_W-1:0] lk_row_o;

  ict_table #(.LANES(LANES), .SLOTS(SLOTS), .ID_W(ID_W), .LSRC_W(LSRC_W), .OFF_W(OFF_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .enq_valid_i(enq_valid_i), .enq_ready_o(enq_ready_o), .enq_row_i(enq_row_i),
    .enq_id_o(enq_id_o), .full_o(full_o),
    .lk_ready_i(lk_ready_i), .lk_key_i(lk_key_i),
    .lk_valid_o(lk_valid_o), .lk_row_o(lk_row_o)
  );

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;

  // scoreboard model
  bit               m_busy [ROWS];
  logic [ROW_W-1:0] m_data [ROWS];
  logic [ID_W-1:0]  m_ptr = '0;

  typedef struct {
    bit               v;
    logic [ROW_W-1:0] d;
    string            req;
  } exp_t;
  exp_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ROW_W-1:0] mk_row();
    return ROW_W'({$urandom, $urandom});
  endfunction

  // driver: one cycle of stimulus, predicts grant and lookup result
  task automatic step(input bit e, input logic [ROW_W-1:0] d, input bit l,
                      input logic [ID_W-1:0] k, input string req);
    bit              ex_full;
    logic [ID_W-1:0] ex_id;
    exp_t            it;
    @(negedge clk_i);
    enq_valid_i = e; enq_row_i = d; lk_ready_i = l; lk_key_i = k;
    ex_full = 1'b1; ex_id = m_ptr;
    for (int j = ROWS - 1; j >= 0; j--) begin
      logic [ID_W-1:0] c;
      c = m_ptr + ID_W'(j);
      if (!m_busy[c]) begin ex_full = 1'b0; ex_id = c; end
    end
    if (l) begin
      it.v = m_busy[k]; it.d = m_data[k]; it.req = req;
      exp_q.push_back(it);
    end
    #1;
    chk(full_o == ex_full, {req, "/R8 full"}, 64'(full_o), 64'(ex_full));
    chk(enq_ready_o == !ex_full, {req, "/R8 ready"}, 64'(enq_ready_o), 64'(!ex_full));
    if (!ex_full) chk(enq_id_o == ex_id, {req, "/R7 id"}, 64'(enq_id_o), 64'(ex_id));
    if (!l) chk(lk_valid_o == 1'b0, "R6 valid without ready", 64'(lk_valid_o), 64'd0);
    @(posedge clk_i);
    if (l && m_busy[k]) m_busy[k] = 1'b0;
    if (e && !ex_full) begin
      m_busy[ex_id] = 1'b1; m_data[ex_id] = d; m_ptr = ex_id + ID_W'(1);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    enq_valid_i = 1'b0; lk_ready_i = 1'b0;
  endtask

  // monitor: compares lookup results against the queue
  always @(negedge clk_i) begin
    #2;
    if (rst_ni && lk_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "monitor queue underflow", 64'd0, 64'd1);
      end else begin
        exp_t it;
        it = exp_q.pop_front();
        chk(lk_valid_o == it.v, {it.req, " lookup valid"}, 64'(lk_valid_o), 64'(it.v));
        if (it.v) chk(lk_row_o == it.d, {it.req, "/R3 lookup row"}, 64'(lk_row_o), 64'(it.d));
      end
    end
  end

  bit done = 1'b0;

  initial begin
    #(100000 * 10);
    if (!done) begin
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ROWS; i++) begin m_busy[i] = 1'b0; m_data[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1 reset state
    chk(full_o == 1'b0, "R1 full after reset", 64'(full_o), 64'd0);
    chk(enq_ready_o == 1'b1, "R1 ready after reset", 64'(enq_ready_o), 64'd1);
    chk(enq_id_o == '0, "R1 id after reset", 64'(enq_id_o), 64'd0);
    for (int k = 0; k < ROWS; k++) step(1'b0, '0, 1'b1, ID_W'(k), "R1 empty lookup");

    // R2 sequential grants, R3 storage
    for (int n = 0; n < 3; n++) step(1'b1, mk_row(), 1'b0, '0, "R2 grant");
    step(1'b0, '0, 1'b1, 3'd1, "R3 R5 hit");
    step(1'b0, '0, 1'b1, 3'd1, "R5 second lookup misses");
    step(1'b0, '0, 1'b1, 3'd5, "R4 invalid key");
    step(1'b0, '0, 1'b1, 3'd0, "R4 row 0 untouched");
    step(1'b1, mk_row(), 1'b0, '0, "R7 reuse after free");

    // fill up: counter wraps and skips busy rows
    for (int n = 0; n < 6; n++) step(1'b1, mk_row(), 1'b0, '0, "R7 fill");
    step(1'b1, mk_row(), 1'b0, '0, "R8 enqueue while full");
    step(1'b1, mk_row(), 1'b0, '0, "R8 enqueue while full again");

    // R10: free a row while full, enqueue refused this cycle
    step(1'b1, mk_row(), 1'b1, 3'd4, "R10 free while full");
    step(1'b1, mk_row(), 1'b0, '0, "R10 refill freed row");
    step(1'b0, '0, 1'b1, 3'd4, "R10 freed row holds new data");

    // R9: enqueue and lookup in the same cycle
    step(1'b1, mk_row(), 1'b1, 3'd0, "R9 same-cycle");
    step(1'b0, '0, 1'b1, 3'd0, "R9 looked-up row gone");
    step(1'b0, '0, 1'b1, 3'd4, "R9 enqueued row present");

    // drain everything, content check for rows left through the full phase
    for (int k = 0; k < ROWS; k++) step(1'b0, '0, 1'b1, ID_W'(k), "R8 drain");

    // mixed traffic
    for (int n = 0; n < 300; n++)
      step(1'($urandom), mk_row(), 1'($urandom), ID_W'($urandom), "R9 mixed");
    for (int k = 0; k < ROWS; k++) step(1'b0, '0, 1'b1, ID_W'(k), "R3 final drain");
    idle();
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "monitor queue drained", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule